// File: doc/BRIEF.md
# Center-Aligned PWM Generator with Valley Update Event

This block produces a symmetric PWM waveform from an up/down carrier and raises a periodic one-clock update strobe timed to the middle of the active pulse. A current-control loop samples the supply-rail current on that strobe: with continuous load current, the instantaneous value at the centre of the on-time equals the average load current.

The carrier steps once per prescaled tick. It climbs from zero to the active top value, falls back to zero, and repeats. The output is active while the carrier is below the active duty value, so each pulse is centred on the carrier valley. A turnaround counter counts carrier reversals at both peak and valley and fires the update only at a valley. The duty value written by software is held in a buffer. The top value input is sampled only on an update, so a new pulse shape never starts partway through a pulse. Each update also sets a sticky flag that software clears.

Top module: `cpwm_center_update`

## Requirements
- R1: The carrier starts at 0 counting up, reaches the active top T, then counts down to 0 and repeats, moving one step per tick, so one PWM period is 2*T ticks; a top_i of 0 is used as 1.
- R2: A tick occurs once every psc_div_i+1 clocks, so one PWM period lasts (psc_div_i+1)*2*T clocks.
- R3: pwm_o is high while the carrier is below the active duty D; for 1 <= D < T it is high (psc_div_i+1)*(2*D-1) clocks per period.
- R4: An active duty of 0 keeps pwm_o low, and an active duty at or above T keeps pwm_o high.
- R5: update_o is a one-clock pulse in the first clock of the carrier's zero state; for 1 <= D < T, pwm_o has been high for exactly (psc_div_i+1)*(D-1) clocks just before it and stays high for (psc_div_i+1)*D clocks starting with it.
- R6: Consecutive update pulses are floor(R/2)+1 PWM periods apart, where R is the rep_i value sampled at the earlier pulse.
- R7: duty_wr_i high at a clock edge stores duty_i in a buffer; the active duty takes the buffered value only on an update.
- R8: top_i is copied into the active top only on an update; changing it between updates leaves the current update spacing unchanged.
- R9: irq_o is set by every update, stays set until irq_clr_i is high for one clock, and a set and a clear in the same clock leave it set.
- R10: During reset pwm_o, update_o and irq_o are low; after reset the active duty is 0 and the active top is 1 until the first update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_div_i | input | 8 | Prescale divide minus one |
| top_i | input | 12 | Requested carrier top value |
| rep_i | input | 8 | Turnaround count between updates |
| duty_wr_i | input | 1 | Strobe to store duty_i in the buffer |
| duty_i | input | 12 | Requested compare value |
| irq_clr_i | input | 1 | Clears the sticky update flag |
| pwm_o | output | 1 | PWM output |
| update_o | output | 1 | One-clock update strobe at the pulse centre |
| irq_o | output | 1 | Sticky update flag |

## Verification
Randomly drawn prescale, top, turnaround and duty settings are compared with arithmetic predictions of update spacing, total high time and the split of the active pulse around the strobe. Together these separate prescale errors, carrier-period errors, off-centre strobes and compare-edge mistakes. Directed cases cover the duty extremes of zero, equal to top and above top, a zero top, an even turnaround count, and a duty or top change made between updates. The old value must persist until the next strobe in the last two. The flag is checked on a plain clear and on a clear that lands on the same clock as an update.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/cpwm_prescaler.sv
`timescale 1ns/1ps
module cpwm_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_q, psc_d;

  always_comb begin
    tick_o = (psc_q >= div_i);
    psc_d  = tick_o ? '0 : psc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

  // after a tick the next one follows at once only for a divide of one
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/cpwm_carrier.sv
`timescale 1ns/1ps
module cpwm_carrier
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             peak_o,
  output logic             valley_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  cnt_dir_e         dir_q, dir_d;

  always_comb begin
    cnt_d    = cnt_q;
    dir_d    = dir_q;
    peak_o   = 1'b0;
    valley_o = 1'b0;
    if (tick_i) begin
      if (dir_q == DIR_UP) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q >= top_i - 1'b1) begin
          dir_d  = DIR_DOWN;
          peak_o = 1'b1;
        end
      end else begin
        if (cnt_q <= CNT_W'(1)) begin
          cnt_d    = '0;
          dir_d    = DIR_UP;
          valley_o = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o = cnt_q;

  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= top_i);
  p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/cpwm_rep_timer.sv
`timescale 1ns/1ps
module cpwm_rep_timer #(
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             peak_i,
  input  logic             valley_i,
  input  logic [REP_W-1:0] rep_i,
  output logic             fire_o
);
  logic [REP_W-1:0] rep_q, rep_d;
  logic             expired;

  always_comb begin
    expired = (rep_q == '0);
    fire_o  = valley_i && expired;
    rep_d   = rep_q;
    if (peak_i || valley_i) begin
      if (!expired)      rep_d = rep_q - 1'b1;
      else if (valley_i) rep_d = rep_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rep_q <= '0;
    else        rep_q <= rep_d;
  end

  p_reload_on_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> rep_q == $past(rep_i));
  p_no_peak_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    peak_i |-> !fire_o);
endmodule

// File: rtl/cpwm_center_update.sv
`timescale 1ns/1ps
module cpwm_center_update #(
  parameter int CNT_W = 12,
  parameter int PSC_W = 8,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc_div_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [REP_W-1:0] rep_i,
  input  logic             duty_wr_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             irq_clr_i,
  output logic             pwm_o,
  output logic             update_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] TOP_MIN = CNT_W'(1);

  logic             tick, peak, valley, fire;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] top_eff;
  logic [CNT_W-1:0] duty_buf_q, duty_buf_d;
  logic [CNT_W-1:0] duty_act_q, duty_act_d;
  logic [CNT_W-1:0] top_act_q, top_act_d;
  logic             update_q, irq_q, irq_d;

  cpwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .div_i(psc_div_i), .tick_o(tick)
  );

  cpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .top_i(top_act_q),
    .cnt_o(cnt), .peak_o(peak), .valley_o(valley)
  );

  cpwm_rep_timer #(.REP_W(REP_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .peak_i(peak), .valley_i(valley),
    .rep_i(rep_i), .fire_o(fire)
  );

  always_comb begin
    top_eff    = (top_i == '0) ? TOP_MIN : top_i;
    duty_buf_d = duty_wr_i ? duty_i : duty_buf_q;
    duty_act_d = fire ? duty_buf_q : duty_act_q;
    top_act_d  = fire ? top_eff : top_act_q;
    irq_d      = fire ? 1'b1 : (irq_clr_i ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_buf_q <= '0;
      duty_act_q <= '0;
      top_act_q  <= TOP_MIN;
      update_q   <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      duty_buf_q <= duty_buf_d;
      duty_act_q <= duty_act_d;
      top_act_q  <= top_act_d;
      update_q   <= fire;
      irq_q      <= irq_d;
    end
  end

  assign pwm_o    = (duty_act_q >= top_act_q) || (cnt < duty_act_q);
  assign update_o = update_q;
  assign irq_o    = irq_q;

  p_update_at_valley_r5: assert property (@(posedge clk) disable iff (!rst_n)
    update_q |-> cnt == '0);
  p_update_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    update_q |=> !update_q);
  p_top_change_on_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(top_act_q) |-> update_q);
  p_duty_change_on_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_act_q) |-> update_q);
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    update_q |-> irq_q);
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr_i) |=> irq_q);
endmodule

// File: tb/cpwm_center_update_tb.sv
`timescale 1ns/1ps
module cpwm_center_update_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  psc_div_i;
  logic [11:0] top_i;
  logic [7:0]  rep_i;
  logic        duty_wr_i;
  logic [11:0] duty_i;
  logic        irq_clr_i;
  logic        pwm_o, update_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  cpwm_center_update u_dut (
    .clk(clk), .rst_n(rst_n), .psc_div_i(psc_div_i), .top_i(top_i),
    .rep_i(rep_i), .duty_wr_i(duty_wr_i), .duty_i(duty_i),
    .irq_clr_i(irq_clr_i), .pwm_o(pwm_o), .update_o(update_o), .irq_o(irq_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_top(input int top);
    return (top == 0) ? 1 : top;
  endfunction

  function automatic int exp_ivl(input int psc, input int top, input int rep);
    return (psc + 1) * 2 * eff_top(top) * (rep / 2 + 1);
  endfunction

  function automatic int exp_high(input int psc, input int top, input int rep, input int duty);
    int t = eff_top(top);
    if (duty == 0) return 0;
    if (duty >= t) return exp_ivl(psc, top, rep);
    return (rep / 2 + 1) * (psc + 1) * (2 * duty - 1);
  endfunction

  task automatic wait_update();
    int g = 0;
    do begin
      step();
      g++;
    end while (!update_o && g < 20000);
  endtask

  // starts on an update cycle, ends on the next one
  task automatic count_interval(output int ivl, output int hi, output int post);
    bit inpost = 1;
    ivl = 0; hi = 0; post = 0;
    do begin
      ivl++;
      if (pwm_o) hi++;
      if (inpost && pwm_o) post++;
      else inpost = 0;
      step();
    end while (!update_o && ivl < 20000);
  endtask

  task automatic measure(output int pre, output int ivl, output int hi, output int post);
    int run = 0;
    int g = 0;
    forever begin
      step();
      g++;
      if (update_o || g > 20000) break;
      run = pwm_o ? run + 1 : 0;
    end
    pre = run;
    count_interval(ivl, hi, post);
  endtask

  task automatic configure(input int psc, input int top, input int rep, input int duty);
    psc_div_i = 8'(psc);
    top_i     = 12'(top);
    rep_i     = 8'(rep);
    duty_i    = 12'(duty);
    duty_wr_i = 1'b1;
    step();
    duty_wr_i = 1'b0;
    wait_update();
  endtask

  task automatic trial(input int psc, input int top, input int rep, input int duty);
    int pre, ivl, hi, post;
    configure(psc, top, rep, duty);
    measure(pre, ivl, hi, post);
    check($sformatf("R2 R6 R1 spacing psc=%0d top=%0d rep=%0d", psc, top, rep),
          ivl, exp_ivl(psc, top, rep));
    check($sformatf("R3 R4 high time top=%0d duty=%0d", top, duty),
          hi, exp_high(psc, top, rep, duty));
    if (duty >= 1 && duty < eff_top(top)) begin
      check($sformatf("R5 high before strobe duty=%0d", duty), pre, (psc + 1) * (duty - 1));
      check($sformatf("R5 high from strobe duty=%0d", duty), post, (psc + 1) * duty);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int pre, ivl, hi, post;
    void'($urandom(32'h1A2B));
    rst_n = 1'b0; psc_div_i = '0; top_i = 12'd8; rep_i = '0;
    duty_wr_i = 1'b0; duty_i = '0; irq_clr_i = 1'b0;
    repeat (3) step();
    check("R10 pwm in reset", pwm_o, 0);
    check("R10 update in reset", update_o, 0);
    check("R10 flag in reset", irq_o, 0);
    rst_n = 1'b1;
    step();
    check("R10 pwm low after reset with zero duty", pwm_o, 0);

    // directed shapes
    trial(0, 8, 1, 3);
    trial(2, 10, 3, 4);
    trial(1, 6, 4, 2);      // even turnaround count
    trial(0, 5, 0, 0);      // R4 zero duty
    trial(0, 5, 1, 5);      // R4 duty equal to top
    trial(1, 5, 1, 9);      // R4 duty above top
    trial(0, 0, 1, 1);      // R1 zero top used as one
    trial(3, 7, 5, 1);

    // R7: duty written between updates applies at the next strobe only
    configure(0, 10, 3, 2);
    step();
    duty_i = 12'd6; duty_wr_i = 1'b1; step(); duty_wr_i = 1'b0;
    measure(pre, ivl, hi, post);
    check("R7 old duty before strobe", pre, 1);
    check("R7 new duty from strobe", post, 6);

    // R8: top change between updates keeps the current spacing
    configure(0, 10, 1, 3);
    top_i = 12'd6;
    count_interval(ivl, hi, post);
    check("R8 spacing keeps old top", ivl, 20);
    count_interval(ivl, hi, post);
    check("R8 spacing uses new top", ivl, 12);

    // R9: sticky flag, clear, and set beating clear
    check("R9 flag set by update", irq_o, 1);
    repeat (3) step();
    check("R9 flag held", irq_o, 1);
    irq_clr_i = 1'b1; step(); irq_clr_i = 1'b0;
    check("R9 flag cleared", irq_o, 0);
    step();
    check("R9 flag stays clear", irq_o, 0);
    wait_update();
    check("R9 flag set again", irq_o, 1);
    repeat (11) step();
    irq_clr_i = 1'b1; step(); irq_clr_i = 1'b0;
    check("R9 update present at collision", update_o, 1);
    check("R9 set beats clear", irq_o, 1);

    // constrained random settings
    for (int i = 0; i < 10; i++) begin
      int psc  = int'($urandom_range(3, 0));
      int top  = int'($urandom_range(24, 2));
      int rep  = int'($urandom_range(5, 0));
      int duty = int'($urandom_range(top + 2, 0));
      trial(psc, top, rep, duty);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule